// File: doc/BRIEF.md
# Inter-Processor Interrupt Controller

This block lets the CPUs of a small multicore cluster interrupt one another and pass a short message along with the interrupt. Every CPU owns two 32-bit words in the block's address window: a control word that it writes to send or acknowledge, and a status word that holds the last message delivered to it. There is one interrupt output per CPU, and it follows that CPU's pending flag.

A CPU sends by writing its own control word with the generate bit set, a destination ID and 16 bits of payload. The destination's status word is then overwritten with the pending flag, the sender's index and the payload, and the destination's interrupt goes high. The receiver reads its status word to get the message. It then writes its own control word with the acknowledge bit set, which clears the pending flag and drops its interrupt.

The bus side is a single synchronous port with address, write enable, write data, read enable and registered read data. Because there is one port, only one delivery can happen in a cycle.

Top module: `ipi_ctrl`

## Requirements
- R1: Address bit 2 selects the register: 0 is the control word and 1 is the status word. Bits from 3 upward give the CPU index. Address bits 1:0 are ignored.
- R2: A write to a valid control address stores all 32 data bits, whatever bits are set. A later read of that address returns the stored value.
- R3: Read data appears on `bus_rdata` one clock after the cycle in which `bus_rd` is high. It holds its value while `bus_rd` is low.
- R4: A control write with bit 30 (generate) set and a destination ID (bits 29:16) below N_CPU does three things. It overwrites the destination's status with bit 30 = 1, the writer's index in bits 29:16 and the write data bits 15:0 in bits 15:0 (bit 31 = 0). It also raises that destination's interrupt one clock after the write.
- R5: A control write with bit 31 (acknowledge) set clears bit 30 of the writer's own status and lowers its interrupt one clock later. Status bits 29:0 are kept.
- R6: When one write sets both generate and acknowledge and the destination is the writer itself, the message is stored and the pending flag ends cleared.
- R7: A write to any status address changes no register and no interrupt line.
- R8: A generate request whose destination ID is N_CPU or above delivers nothing. The control word is still stored.
- R9: An access to a CPU index of N_CPU or above reads as zero and has no write effect.
- R10: A new delivery to a CPU whose pending flag is already set replaces the old source and payload.
- R11: Reset clears every control and status word, the read data and every interrupt line.
- R12: Each interrupt output is registered and always equals its CPU's pending flag. It changes only on a delivery to that CPU or an acknowledge by that CPU.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address inside the block window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid one clock after the read strobe |
| irq_out | output | N_CPU | Interrupt line per CPU, equal to its pending flag |

## Verification
A wrong pending flag shows up on that CPU's interrupt line in the clock after the write that caused it, because the line copies the flag. A wrong source, payload or stored control value stays hidden until someone reads that register. The read data shows it one clock after the read strobe. For that reason the bench reads back every control and status word after each write in its sweeps, and does not rely on the interrupt lines alone. Deliveries from every source to every destination, destinations out of range, and addresses out of range are all swept, so that misrouting or an unwanted side effect on a neighbouring CPU is caught within a few cycles.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
   localparam int WORD_W   = 32;
   localparam int ID_W     = 14;
   localparam int MSG_W    = 16;
   localparam int ACK_POS  = 31;
   localparam int GEN_POS  = 30;
   localparam int DST_LSB  = 16;
   localparam int SEL_POS  = 2;
   localparam int IDX_LSB  = 3;

   // Status word content below bit 31 (which always reads zero)
   typedef struct packed {
      logic             pend;
      logic [ID_W-1:0]  src;
      logic [MSG_W-1:0] msg;
   } ipi_status_t;

   function automatic logic [WORD_W-1:0] status_word(input ipi_status_t s);
      return {1'b0, s};
   endfunction

   function automatic logic [ID_W-1:0] dst_field(input logic [WORD_W-1:0] w);
      return w[DST_LSB +: ID_W];
   endfunction
endpackage

// File: rtl/ipi_addr_dec.sv
module ipi_addr_dec
   import ipi_pkg::*;
#(
   parameter int N_CPU  = 4,
   parameter int ADDR_W = 8,
   localparam int IDX_W = ADDR_W - IDX_LSB
)(
   input  logic [ADDR_W-1:SEL_POS] addr_hi,
   input  logic                    wr,
   input  logic [WORD_W-1:0]       wdata,
   output logic                    idx_ok,
   output logic                    sel_status,
   output logic [IDX_W-1:0]        cpu_idx,
   output logic [ID_W-1:0]         src_id,
   output logic [N_CPU-1:0]        ctl_we,
   output logic [N_CPU-1:0]        ack_hit,
   output logic [N_CPU-1:0]        deliver
);
   logic [31:0]     idx_wide;
   logic [ID_W-1:0] dst_id;
   logic            ctl_wr;

   assign cpu_idx    = addr_hi[ADDR_W-1:IDX_LSB];
   assign sel_status = addr_hi[SEL_POS];
   assign idx_wide   = 32'(cpu_idx);
   assign idx_ok     = (idx_wide < 32'(N_CPU));
   assign src_id     = idx_wide[ID_W-1:0];
   assign dst_id     = dst_field(wdata);
   assign ctl_wr     = wr && !sel_status && idx_ok;

   for (genvar i = 0; i < N_CPU; i++) begin : g_hit
      assign ctl_we[i]  = ctl_wr && (cpu_idx == IDX_W'(i));
      assign ack_hit[i] = ctl_we[i] && wdata[ACK_POS];
      assign deliver[i] = ctl_wr && wdata[GEN_POS] && (dst_id == ID_W'(i));
   end
endmodule

// File: rtl/ipi_slot.sv
module ipi_slot
   import ipi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_we,
   input  logic              ack,
   input  logic              deliver,
   input  logic [ID_W-1:0]   src_id,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] ctl_q,
   output ipi_status_t       st_q,
   output logic              irq_q
);
   ipi_status_t st_n;

   // Delivery is applied first, then the acknowledge
   always_comb begin
      st_n = st_q;
      if (deliver) begin
         st_n.pend = 1'b1;
         st_n.src  = src_id;
         st_n.msg  = wdata[MSG_W-1:0];
      end
      if (ack) begin
         st_n.pend = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
         st_q  <= '0;
         irq_q <= 1'b0;
      end else begin
         if (ctl_we) begin
            ctl_q <= wdata;
         end
         st_q  <= st_n;
         irq_q <= st_n.pend;
      end
   end
endmodule

// File: rtl/ipi_rd_path.sv
module ipi_rd_path
   import ipi_pkg::*;
#(
   parameter int N_CPU    = 4,
   parameter int IDX_W    = 5,
   parameter bit RD_FLOP  = 1'b1
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rd,
   input  logic                          idx_ok,
   input  logic                          sel_status,
   input  logic [IDX_W-1:0]              cpu_idx,
   input  logic [N_CPU-1:0][WORD_W-1:0]  ctl_arr,
   input  logic [N_CPU-1:0][WORD_W-1:0]  st_arr,
   output logic [WORD_W-1:0]             rdata
);
   logic [WORD_W-1:0] sel_word;

   always_comb begin
      sel_word = '0;
      for (int i = 0; i < N_CPU; i++) begin
         if (idx_ok && cpu_idx == IDX_W'(i)) begin
            sel_word = sel_status ? st_arr[i] : ctl_arr[i];
         end
      end
   end

   if (RD_FLOP) begin : g_flop
      logic [WORD_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rdata_q <= '0;
         end else if (rd) begin
            rdata_q <= sel_word;
         end
      end
      assign rdata = rdata_q;
   end else begin : g_comb
      logic unused_rd_clk;
      assign unused_rd_clk = clk ^ rst_n;
      assign rdata = rd ? sel_word : '0;
   end
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
   import ipi_pkg::*;
#(
   parameter int N_CPU     = 4,
   parameter int CPU_LIMIT = 4,
   parameter int ADDR_W    = 8,
   parameter bit RD_FLOP   = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic [N_CPU-1:0]  irq_out
);
   localparam int IDX_W = ADDR_W - IDX_LSB;

   if (N_CPU < 1 || N_CPU > CPU_LIMIT) begin : g_bad_count
      $error("ipi_ctrl: N_CPU must lie in 1..CPU_LIMIT");
   end
   if (ADDR_W < IDX_LSB + 1 || IDX_W < $clog2(N_CPU)) begin : g_bad_addr
      $error("ipi_ctrl: ADDR_W too narrow for N_CPU");
   end

   logic                         idx_ok;
   logic                         sel_status;
   logic [IDX_W-1:0]             cpu_idx;
   logic [ID_W-1:0]              src_id;
   logic [N_CPU-1:0]             ctl_we;
   logic [N_CPU-1:0]             ack_hit;
   logic [N_CPU-1:0]             deliver;
   logic [N_CPU-1:0][WORD_W-1:0] ctl_arr;
   logic [N_CPU-1:0][WORD_W-1:0] st_arr;
   logic [N_CPU-1:0]             pend_vec;
   logic [1:0]                   unused_addr_lo;

   assign unused_addr_lo = bus_addr[1:0];

   ipi_addr_dec #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) u_dec (
      .addr_hi    (bus_addr[ADDR_W-1:SEL_POS]),
      .wr         (bus_wr),
      .wdata      (bus_wdata),
      .idx_ok     (idx_ok),
      .sel_status (sel_status),
      .cpu_idx    (cpu_idx),
      .src_id     (src_id),
      .ctl_we     (ctl_we),
      .ack_hit    (ack_hit),
      .deliver    (deliver)
   );

   for (genvar i = 0; i < N_CPU; i++) begin : g_slot
      ipi_status_t st_q;
      ipi_slot u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .ctl_we  (ctl_we[i]),
         .ack     (ack_hit[i]),
         .deliver (deliver[i]),
         .src_id  (src_id),
         .wdata   (bus_wdata),
         .ctl_q   (ctl_arr[i]),
         .st_q    (st_q),
         .irq_q   (irq_out[i])
      );
      assign st_arr[i]   = status_word(st_q);
      assign pend_vec[i] = st_q.pend;
   end

   ipi_rd_path #(.N_CPU(N_CPU), .IDX_W(IDX_W), .RD_FLOP(RD_FLOP)) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd         (bus_rd),
      .idx_ok     (idx_ok),
      .sel_status (sel_status),
      .cpu_idx    (cpu_idx),
      .ctl_arr    (ctl_arr),
      .st_arr     (st_arr),
      .rdata      (bus_rdata)
   );
endmodule

// File: rtl/ipi_ctrl_chk.sv
module ipi_ctrl_chk #(
   parameter int N_CPU  = 4,
   parameter int ADDR_W = 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [31:0]       bus_wdata,
   input logic [N_CPU-1:0]  irq_out,
   input logic [N_CPU-1:0]  pend_vec
);
   localparam int IDX_W = ADDR_W - 3;

   logic [N_CPU-1:0] gen_to;
   logic [N_CPU-1:0] ack_from;
   logic             ctl_write;
   logic             stray_write;
   logic [15:0]      unused_chk_msg;

   assign unused_chk_msg = bus_wdata[15:0];
   assign ctl_write   = bus_wr && !bus_addr[2] && (32'(bus_addr[ADDR_W-1:3]) < 32'(N_CPU));
   assign stray_write = bus_wr && (bus_addr[2] || (32'(bus_addr[ADDR_W-1:3]) >= 32'(N_CPU)));

   for (genvar i = 0; i < N_CPU; i++) begin : g_chk
      assign gen_to[i]   = ctl_write && bus_wdata[30] && (bus_wdata[29:16] == 14'(i));
      assign ack_from[i] = ctl_write && bus_wdata[31] && (bus_addr[ADDR_W-1:3] == IDX_W'(i));

      // R4
      a_r4_gen_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
         (gen_to[i] && !ack_from[i]) |=> irq_out[i]);
      // R5 and R6
      a_r5_ack_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
         ack_from[i] |=> !irq_out[i]);
      // R12
      a_r12_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!gen_to[i] && !ack_from[i]) |=> $stable(irq_out[i]));
      // R12
      a_r12_irq_is_pend: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out[i] == pend_vec[i]);
   end

   // R7 and R9
   a_r9_stray_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      stray_write |=> $stable(irq_out));

   // R11
   a_r11_reset_clears: assert property (@(posedge clk)
      !rst_n |=> (irq_out == '0));
endmodule

bind ipi_ctrl ipi_ctrl_chk #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .irq_out   (irq_out),
   .pend_vec  (pend_vec)
);

// File: tb/ipi_ctrl_tb_top.sv
`timescale 1ns/1ps
module ipi_ctrl_tb_top;
   localparam int N  = 4;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] bus_addr;
   logic          bus_wr;
   logic [31:0]   bus_wdata;
   logic          bus_rd;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  irq_out;

   always #2.5 clk = ~clk;

   ipi_ctrl #(.N_CPU(N), .CPU_LIMIT(4), .ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .irq_out(irq_out)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [31:0] m_ctl [N];
   logic [31:0] m_st  [N];

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] m_irq();
      logic [31:0] v = '0;
      for (int i = 0; i < N; i++) v[i] = m_st[i][30];
      return v;
   endfunction

   task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d);
      int idx = int'(a[AW-1:3]);
      if (idx < N && !a[2]) begin
         m_ctl[idx] = d;
         if (d[30] && int'(d[29:16]) < N)
            m_st[int'(d[29:16])] = {2'b01, 14'(idx), d[15:0]};
         if (d[31]) m_st[idx][30] = 1'b0;
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, d);
   endtask

   task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      chk(req, bus_rdata, exp);
   endtask

   task automatic chk_all(input string req);
      chk({req, " R12 irq"}, 32'(irq_out), m_irq());
      for (int i = 0; i < N; i++) begin
         rd_chk({req, " R2 ctl"}, AW'(i * 8),     m_ctl[i]);
         rd_chk({req, " R4 st"},  AW'(i * 8 + 4), m_st[i]);
      end
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin m_ctl[i] = '0; m_st[i] = '0; end
      rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; bus_rd = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R11 reset state
      chk("R11 rdata", bus_rdata, 32'h0);
      chk("R11 irq", 32'(irq_out), 32'h0);
      chk_all("R11");

      // R2 plain control writes
      for (int i = 0; i < N; i++)
         wr(AW'(i * 8), {2'b00, 14'(16'h03A5 + i), 16'hC0DE ^ 16'(i)});
      chk_all("R2");

      // R4 / R5 every source to every destination, then acknowledge
      for (int s = 0; s < N; s++) begin
         for (int d = 0; d < N; d++) begin
            wr(AW'(s * 8), {2'b01, 14'(d), 16'(16'hA500 + s * 16 + d)});
            chk("R4 irq after gen", 32'(irq_out), m_irq());
            rd_chk("R4 status", AW'(d * 8 + 4), {2'b01, 14'(s), 16'(16'hA500 + s * 16 + d)});
            wr(AW'(d * 8), 32'h8000_0000);
            chk("R5 irq after ack", 32'(irq_out), m_irq());
            rd_chk("R5 status kept", AW'(d * 8 + 4), {2'b00, 14'(s), 16'(16'hA500 + s * 16 + d)});
         end
      end
      chk_all("R4 sweep");

      // R10 overwrite while pending
      wr(AW'(8),  {2'b01, 14'd2, 16'h1111});
      wr(AW'(24), {2'b01, 14'd2, 16'h2222});
      rd_chk("R10 overwrite", AW'(20), {2'b01, 14'd3, 16'h2222});
      chk("R10 irq", 32'(irq_out), m_irq());

      // R6 generate and acknowledge to self in one write
      wr(AW'(16), {2'b11, 14'd2, 16'h5A5A});
      rd_chk("R6 self", AW'(20), {2'b00, 14'd2, 16'h5A5A});
      chk("R6 irq", 32'(irq_out[2]), 32'h0);
      rd_chk("R6 ctl", AW'(16), {2'b11, 14'd2, 16'h5A5A});

      // R8 destination out of range
      wr(AW'(0), {2'b01, 14'd4, 16'hBEEF});
      wr(AW'(8), {2'b01, 14'h3FFF, 16'hFEED});
      chk_all("R8");

      // R7 writes to status addresses
      wr(AW'(0), {2'b01, 14'd1, 16'h7777});
      for (int i = 0; i < N; i++)
         wr(AW'(i * 8 + 4), {2'b11, 14'(i), 16'h0BAD});
      chk_all("R7");

      // R9 out-of-range CPU index
      for (int k = N; k < 32; k++) begin
         wr(AW'(k * 8), {2'b11, 14'd0, 16'(k)});
         rd_chk("R9 ctl zero", AW'(k * 8), 32'h0);
         rd_chk("R9 st zero",  AW'(k * 8 + 4), 32'h0);
         chk("R9 irq", 32'(irq_out), m_irq());
      end
      chk_all("R9");

      // R1 low address bits ignored
      wr(AW'(8'h0B), 32'h1357_9BDF);
      rd_chk("R1 ctl alias", AW'(8'h08), 32'h1357_9BDF);
      rd_chk("R1 st alias",  AW'(8'h0F), m_st[1]);
      rd_chk("R1 bit2 sel",  AW'(8'h0D), m_st[1]);

      // R3 read data holds without a read strobe
      rd_chk("R3 read", AW'(8'h08), 32'h1357_9BDF);
      @(negedge clk); bus_addr = AW'(8'h04);
      repeat (3) @(negedge clk);
      chk("R3 hold", bus_rdata, 32'h1357_9BDF);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule